// File: doc/BRIEF.md
# DRAM Row/Column Access Controller

This block turns single-word requests from on-chip logic into DRAM access cycles. A request carries a word address, a read/write flag, two byte enables and write data, and is accepted with a valid/ready handshake. The controller places the row part of the address and then the column part on one shared 13-bit address bus. It drives an active-low row strobe, two active-low column strobes (one for the even byte and one for the odd byte) and an active-low write enable.

Read data is captured at the end of the column strobe and is returned with a one-cycle done pulse. Writes also produce the done pulse. A refresh request input starts a CAS-before-RAS refresh cycle. Refresh is taken only from idle and takes priority over a waiting access. The column strobe length (`CAS_CYC`) and the precharge length (`PRE_CYC`) are parameters.

Top module: `dram_rc_ctrl`

## Requirements
- R1: After reset `req_ready_o`=1, `ras_no`=`casl_no`=`cash_no`=`dw_no`=1, `done_o`=0, `ma_o`=0. `req_ready_o` is high only while idle with `refresh_i` low, and a request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high.
- R2: The cycle after acceptance, `ma_o` carries the row (`req_addr_i[ROW_W+COL_W-1:COL_W]`, zero-extended) with `ras_no` high. In the next cycle `ras_no` falls and the row is still on `ma_o`.
- R3: The third cycle after acceptance carries the column (`req_addr_i[COL_W-1:0]`, zero-extended) on `ma_o`, with `ras_no` low and both column strobes high. The selected column strobes are then low for exactly `CAS_CYC` cycles.
- R4: `req_be_i[0]` selects `casl_no` (even byte) and `req_be_i[1]` selects `cash_no` (odd byte). `req_be_i`=2'b11 lowers both together, and `req_be_i`=2'b00 is treated as 2'b11.
- R5: For a write, `dw_no` is low and `dq_oe_o` is high with `dq_o` equal to the write data, from the column cycle through the last column strobe cycle. For a read, `dw_no` stays high and `dq_oe_o` stays low.
- R6: `dq_i` is captured on the last column strobe cycle. In the following cycle `rd_data_o` holds that value and `done_o` is high for exactly one cycle, for reads and writes alike.
- R7: After the column strobe, all strobes stay high for `PRE_CYC` cycles, and `req_ready_o` returns high in the cycle after those.
- R8: A refresh taken from idle gives one cycle with both column strobes low, `ras_no` high and `ref_ack_o` high. Then follow `CAS_CYC` cycles with `ras_no` and both column strobes low, then `PRE_CYC` precharge cycles.
- R9: When `refresh_i` and `req_valid_i` are both high in idle, the refresh runs first and the request is accepted once the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ROW_W+COL_W | Word address: row high, column low |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| req_wdata_i | input | 16 | Write data |
| refresh_i | input | 1 | Refresh request (level) |
| ref_ack_o | output | 1 | Refresh cycle started |
| rd_data_o | output | 16 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| ma_o | output | MA_W | Multiplexed row/column address |
| ras_no | output | 1 | Row strobe, active low |
| casl_no | output | 1 | Even-byte column strobe, active low |
| cash_no | output | 1 | Odd-byte column strobe, active low |
| dw_no | output | 1 | DRAM write enable, active low |
| dq_o | output | 16 | Write data to DRAM |
| dq_oe_o | output | 1 | Write data drive enable |
| dq_i | input | 16 | Read data from DRAM |

## Verification
The assertions assume that `refresh_i` is a level request that the requester holds until `ref_ack_o` and then drops. They also assume that request fields stay stable only until acceptance, since the controller latches them then. The stimulus changes every input on the falling clock edge and releases `refresh_i` in the cycle where the acknowledge is seen. It drops `req_valid_i` right after acceptance, so no request is taken twice. `dq_i` is set before each read and held through the column strobe, so the captured value is known.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } st_e;
endpackage

// File: rtl/dram_rc_fsm.sv
module dram_rc_fsm
  import dram_rc_pkg::*;
#(
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic refresh_i,
  output st_e  state_o,
  output logic accept_o,
  output logic cas_last_o
);
  localparam int MAXC = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(CAS_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);

  st_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (refresh_i) state_d = ST_RCAS;
               else if (req_valid_i) state_d = ST_ROW;
      ST_ROW:  state_d = ST_RAS;
      ST_RAS:  state_d = ST_COL;
      ST_COL:  state_d = ST_CAS;
      ST_CAS:  if (cnt_q == CAS_LAST) state_d = ST_PRE;
      ST_PRE:  if (cnt_q == PRE_LAST) state_d = ST_IDLE;
      ST_RCAS: state_d = ST_RRAS;
      ST_RRAS: if (cnt_q == CAS_LAST) state_d = ST_PRE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign state_o    = state_q;
  assign accept_o   = (state_q == ST_IDLE) && !refresh_i && req_valid_i;
  assign cas_last_o = (state_q == ST_CAS) && (cnt_q == CAS_LAST);
endmodule

// File: rtl/dram_rc_addr_mux.sv
module dram_rc_addr_mux
  import dram_rc_pkg::*;
#(
  parameter int MA_W  = 13,
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  st_e              state_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [MA_W-1:0]  ma_o
);
  always_comb begin
    unique case (state_i)
      ST_ROW, ST_RAS: ma_o = MA_W'(row_i);
      ST_COL, ST_CAS: ma_o = MA_W'(col_i);
      default:        ma_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_rc_datapath.sv
module dram_rc_datapath
  import dram_rc_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  st_e                    state_i,
  input  logic                   accept_i,
  input  logic                   cas_last_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   we_i,
  input  logic [1:0]             be_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W-1:0]      dq_i,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic [1:0]             mask_o,
  output logic                   we_o,
  output logic [DATA_W-1:0]      dq_o,
  output logic                   dq_oe_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   done_o
);
  logic [ROW_W+COL_W-1:0] addr_q;
  logic                   we_q;
  logic [1:0]             mask_q;
  logic [DATA_W-1:0]      wdata_q, rdata_q;
  logic                   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      mask_q  <= 2'b11;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      mask_q  <= (be_i == 2'b00) ? 2'b11 : be_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= cas_last_i;
      if (cas_last_i && !we_q) rdata_q <= dq_i;
    end
  end

  assign row_o     = addr_q[ROW_W+COL_W-1:COL_W];
  assign col_o     = addr_q[COL_W-1:0];
  assign mask_o    = mask_q;
  assign we_o      = we_q;
  assign dq_o      = wdata_q;
  assign dq_oe_o   = we_q && (state_i == ST_COL || state_i == ST_CAS);
  assign rd_data_o = rdata_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dram_rc_ctrl.sv
module dram_rc_ctrl
  import dram_rc_pkg::*;
#(
  parameter int MA_W    = 13,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 16,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic                   req_we_i,
  input  logic [1:0]             req_be_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  input  logic                   refresh_i,
  output logic                   ref_ack_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   done_o,
  output logic [MA_W-1:0]        ma_o,
  output logic                   ras_no,
  output logic                   casl_no,
  output logic                   cash_no,
  output logic                   dw_no,
  output logic [DATA_W-1:0]      dq_o,
  output logic                   dq_oe_o,
  input  logic [DATA_W-1:0]      dq_i
);
  st_e              state;
  logic             accept, cas_last, we;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [1:0]       mask;

  dram_rc_fsm #(.CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .refresh_i(refresh_i),
    .state_o(state), .accept_o(accept), .cas_last_o(cas_last)
  );

  dram_rc_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .accept_i(accept),
    .cas_last_i(cas_last), .addr_i(req_addr_i), .we_i(req_we_i), .be_i(req_be_i),
    .wdata_i(req_wdata_i), .dq_i(dq_i), .row_o(row), .col_o(col), .mask_o(mask),
    .we_o(we), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .rd_data_o(rd_data_o), .done_o(done_o)
  );

  dram_rc_addr_mux #(.MA_W(MA_W), .ROW_W(ROW_W), .COL_W(COL_W)) i_mux (
    .state_i(state), .row_i(row), .col_i(col), .ma_o(ma_o)
  );

  logic refr;
  assign refr        = (state == ST_RCAS) || (state == ST_RRAS);
  assign req_ready_o = (state == ST_IDLE) && !refresh_i;
  assign ref_ack_o   = (state == ST_RCAS);
  assign ras_no      = !(state == ST_RAS || state == ST_COL || state == ST_CAS || state == ST_RRAS);
  assign casl_no     = !(refr || (state == ST_CAS && mask[0]));
  assign cash_no     = !(refr || (state == ST_CAS && mask[1]));
  assign dw_no       = !(we && (state == ST_COL || state == ST_CAS));
endmodule

// File: rtl/dram_rc_chk.sv
module dram_rc_chk #(
  parameter int MA_W = 13
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            refresh_i,
  input logic            ref_ack_o,
  input logic            done_o,
  input logic [MA_W-1:0] ma_o,
  input logic            ras_no,
  input logic            casl_no,
  input logic            cash_no,
  input logic            dw_no,
  input logic            dq_oe_o
);
  logic cas_any;
  assign cas_any = !casl_no || !cash_no;

  p_ready_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ras_no && casl_no && cash_no && dw_no));
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $stable(ma_o));
  p_dw_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_any && !$past(cas_any)) |-> $stable(dw_no));
  p_dw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_any && $past(cas_any)) |-> $stable(dw_no));
  p_dw_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dw_no |-> (dq_oe_o && !ras_no));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ref_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |-> !req_ready_o);
  p_ref_cbr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |-> (ras_no && !casl_no && !cash_no));
endmodule

bind dram_rc_ctrl dram_rc_chk #(.MA_W(MA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .refresh_i(refresh_i),
  .ref_ack_o(ref_ack_o), .done_o(done_o), .ma_o(ma_o), .ras_no(ras_no),
  .casl_no(casl_no), .cash_no(cash_no), .dw_no(dw_no), .dq_oe_o(dq_oe_o)
);

// File: tb/test_dram_rc_ctrl.sv
module test_dram_rc_ctrl;
  localparam int MA_W = 13, ROW_W = 13, COL_W = 10, DW = 16, CAS = 2, PRE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, refresh = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [1:0] req_be = 2'b11;
  logic [DW-1:0] req_wdata = '0, dq_in = '0;
  logic req_ready, ref_ack, done, ras_n, casl_n, cash_n, dw_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out;
  logic [MA_W-1:0] ma;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_rc_ctrl #(.MA_W(MA_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
                 .CAS_CYC(CAS), .PRE_CYC(PRE)) i_dram_rc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .refresh_i(refresh), .ref_ack_o(ref_ack), .rd_data_o(rd_data), .done_o(done),
    .ma_o(ma), .ras_no(ras_n), .casl_no(casl_n), .cash_no(cash_n), .dw_no(dw_n),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {ras_n, casl_n, cash_n, dw_n};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(strobes() === 4'hF, "R1 strobes idle", 32'(strobes()), 32'hF);
    chk(done === 1'b0 && ma === '0, "R1 done/ma reset", {done, 19'b0, ma}, 0);
  endtask

  // checks from the row cycle on; caller has just raised valid
  task automatic follow(input logic [ROW_W+COL_W-1:0] a, input bit we,
                        input logic [1:0] be, input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    logic [1:0] m;
    logic [MA_W-1:0] r, c;
    m = (be == 2'b00) ? 2'b11 : be;
    r = MA_W'(a[ROW_W+COL_W-1:COL_W]);
    c = MA_W'(a[COL_W-1:0]);
    @(negedge clk); req_valid = 0;
    chk(ras_n && ma == r && !req_ready, "R2 row cycle", {ras_n, 18'b0, ma}, {1'b1, 18'b0, r});
    @(negedge clk);
    chk(!ras_n && ma == r, "R2 ras low row held", {ras_n, 18'b0, ma}, {1'b0, 18'b0, r});
    @(negedge clk);
    chk(ma == c && casl_n && cash_n && !ras_n, "R3 column cycle", {casl_n, cash_n, 17'b0, ma}, {2'b11, 17'b0, c});
    chk(dw_n == !we && dq_oe == we, "R5 write enable at column", {dw_n, dq_oe}, {!we, we});
    for (int i = 0; i < CAS; i++) begin
      @(negedge clk);
      chk({casl_n, cash_n} == ~{m[0], m[1]}, "R4 column strobe mask", {casl_n, cash_n}, ~{m[0], m[1]});
      chk(!ras_n && ma == c && !done, "R3 strobe phase", {ras_n, done, ma}, {2'b00, c});
      chk(dw_n == !we && (!we || dq_out == wd), "R5 write data held", {dw_n, dq_out}, {!we, we ? wd : dq_out});
    end
    @(negedge clk);
    chk(done === 1'b1, "R6 done pulse", 32'(done), 1);
    if (!we) chk(rd_data == rd, "R6 read data", 32'(rd_data), 32'(rd));
    chk(strobes() === 4'hF && !dq_oe, "R7 precharge strobes", 32'(strobes()), 32'hF);
    for (int i = 1; i < PRE; i++) begin
      @(negedge clk);
      chk(!done && !req_ready && strobes() === 4'hF, "R7 precharge hold", {done, req_ready, strobes()}, 6'h0F);
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready after precharge", 32'(req_ready), 1);
  endtask

  task automatic t_access(input logic [ROW_W+COL_W-1:0] a, input bit we,
                          input logic [1:0] be, input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_we = we; req_be = be; req_wdata = wd; dq_in = rd; req_valid = 1;
    follow(a, we, be, wd, rd);
  endtask

  task automatic t_refresh(input bit with_req);
    while (!req_ready) @(negedge clk);
    refresh = 1;
    if (with_req) begin
      req_addr = 23'h4_5A5A; req_we = 0; req_be = 2'b01; dq_in = 16'hC3C3; req_valid = 1;
    end
    @(negedge clk);
    chk(ref_ack && ras_n && !casl_n && !cash_n, "R8 cas before ras", {ref_ack, ras_n, casl_n, cash_n}, 4'b1100);
    chk(!req_ready, "R9 request held off", 32'(req_ready), 0);
    refresh = 0;
    for (int i = 0; i < CAS; i++) begin
      @(negedge clk);
      chk(!ras_n && !casl_n && !cash_n && !ref_ack, "R8 refresh ras phase", {ref_ack, ras_n, casl_n, cash_n}, 0);
    end
    for (int i = 0; i < PRE; i++) begin
      @(negedge clk);
      chk(strobes() === 4'hF && !req_ready, "R8 refresh precharge", {req_ready, strobes()}, 5'h0F);
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 idle after refresh", 32'(req_ready), 1);
    if (with_req) follow(23'h4_5A5A, 0, 2'b01, '0, 16'hC3C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_access(23'h7F_FC01, 0, 2'b11, '0, 16'hBEEF);
    t_access(23'h00_0155, 1, 2'b01, 16'h1234, '0);
    t_access(23'h12_3ABC, 1, 2'b10, 16'hA55A, '0);
    t_access(23'h55_03FF, 0, 2'b00, '0, 16'h0F0F);
    t_access(23'h01_0200, 0, 2'b10, '0, 16'h8001);
    t_refresh(0);
    t_refresh(1);
    t_access(23'h2A_0001, 1, 2'b11, 16'hFFFF, '0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule